// File: doc/BRIEF.md
# I2C Memory Slave Front End

This block is the serial front end of a byte-addressable memory that sits on an I2C bus as a slave. It takes the raw SCL and SDA lines into the system clock domain, filters short glitches out of them and recognises start and stop conditions. It shifts bytes in and out MSB first. It acknowledges by pulling SDA low through an open-drain enable, and it matches the first byte of every transfer against the chip-enable pins and two device type identifiers. One identifier selects the memory array and the other selects a protection register.

The memory controller behind it sees single-cycle framed events: start, stop, a select hit that carries its target and read/write bit, a received byte, and the master's ack or noack after a read byte. A read request pulse asks for the next byte to send. The controller signals a running internal write cycle on `wr_busy`, and the interface then ignores the bus completely. The controller can also disable the protection-register identifier permanently through `prot_locked`.

The control is a seven-state machine. ST_IDLE is standby, and only a start leaves it. ST_SEL shifts in the select byte. It goes to ST_SEL_ACK on the falling SCL edge after a matching eighth bit, and back to ST_IDLE on a mismatch. ST_SEL_ACK drives the ack and then, on the next falling edge, goes to ST_RX for a write or to ST_TX for a read. ST_RX and ST_RX_ACK alternate for each received byte. ST_TX shifts out eight bits and then goes to ST_TX_ACK. From ST_TX_ACK a master ack returns the machine to ST_TX on the next falling edge, and a noack sends it to ST_IDLE. A start in any state leads to ST_SEL, a stop in any state leads to ST_IDLE, and `wr_busy` forces ST_IDLE.

Top module: `i2cfe_slave`

## Requirements
- R1: A start (filtered SDA falls while filtered SCL stays high) pulses `ev_start`. A stop (filtered SDA rises while filtered SCL stays high) pulses `ev_stop`. Start, stop and the two SCL edges are mutually exclusive in any cycle.
- R2: A select byte, sent MSB first, is laid out as type[7:4], chip enable[3:1] and RW[0], with RW=1 meaning read. When type is 4'b1010 and bits [3:1] equal `chip_en`, the slave pulls SDA low for the whole 9th bit and pulses `ev_sel` with `sel_target`=0 and `sel_rw` equal to bit 0.
- R3: Type 4'b0110 with matching chip enable selects the protection register (`sel_target`=1) while `prot_locked` is 0. While `prot_locked` is 1, that type is a mismatch for both read and write, and type 4'b1010 still matches.
- R4: A select byte that does not match gets no ack. The slave then stays in standby until the next start: it acks no further byte and reports no `ev_byte`.
- R5: In a write transfer, each data byte is sampled on rising SCL edges, MSB first. `ev_byte` pulses with the byte on `rx_byte` at the 8th rising edge, and the slave acks the byte in the 9th bit.
- R6: In a read transfer, `rd_req` pulses after the select byte and after each master ack. The byte on `rd_data` is driven MSB first, and SDA is released for the 9th bit. A low 9th bit pulses `ev_mack` and starts the next byte. A high 9th bit pulses `ev_mnack` and returns the slave to standby, so it drives nothing afterwards.
- R7: While `wr_busy` is 1, the interface reports no event, gives no ack (not even to a matching select byte) and stays in standby.
- R8: A repeated start in the middle of a transfer restarts framing: the next byte is decoded as a select byte.
- R9: A level change on SCL or SDA shorter than FILT_LEN system clocks is ignored. A longer one is accepted.
- R10: `sda_oe` goes from 0 to 1 only while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw serial clock line |
| sda_i | input | 1 | Raw serial data line (as seen on the wire) |
| sda_oe | output | 1 | Open-drain enable: 1 pulls SDA low |
| chip_en | input | 3 | Chip-enable pin pattern compared with select bits [3:1] |
| prot_locked | input | 1 | 1 disables the protection-register type identifier |
| wr_busy | input | 1 | Internal write cycle running; bus ignored |
| ev_start | output | 1 | Pulse: start or repeated start seen |
| ev_stop | output | 1 | Pulse: stop seen |
| ev_sel | output | 1 | Pulse: select byte matched |
| sel_target | output | 1 | Target of last select: 0 array, 1 protection register |
| sel_rw | output | 1 | RW bit of last matched select |
| ev_byte | output | 1 | Pulse: data byte received |
| rx_byte | output | 8 | Last received data byte |
| ev_mack | output | 1 | Pulse: master acked a read byte |
| ev_mnack | output | 1 | Pulse: master did not ack a read byte |
| rd_req | output | 1 | Pulse: present the next read byte on rd_data |
| rd_data | input | 8 | Byte to transmit, valid from the cycle after rd_req |

## Verification
Select bytes are tried with the right array type and right chip enable, a wrong chip enable, an unknown type, and the protection type with the lock both clear and set. These cases separate a correct decode of each field from one that ignores a field or the lock. Write transfers with complementary data bytes (3C, C3) expose bit-order and shift errors. Read transfers end first with an ack and then with a noack, followed by an extra clocked byte, which tells a proper return to standby from a slave that keeps driving. A repeated start, a busy window, a short SDA pulse while SCL is high and a long one separate framing reset, lockout and glitch rejection from plain start detection.

// File: rtl/i2cfe_pkg.sv
package i2cfe_pkg;
    localparam int BYTE_W = 8;
    localparam int CE_W   = 3;
    localparam int TYPE_W = 4;
    localparam logic [TYPE_W-1:0] ID_ARRAY = 4'b1010;
    localparam logic [TYPE_W-1:0] ID_PROT  = 4'b0110;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEL,
        ST_SEL_ACK,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK
    } fe_state_t;
endpackage

// File: rtl/i2cfe_line_filter.sv
module i2cfe_line_filter #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic clean
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic          s1, s2;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1    <= 1'b1;
            s2    <= 1'b1;
            cnt   <= '0;
            clean <= 1'b1;
        end else begin
            s1 <= raw;
            s2 <= s1;
            if (s2 != clean) begin
                if (cnt == CW'(FILT_LEN - 1)) begin
                    clean <= s2;
                    cnt   <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else begin
                cnt <= '0;
            end
        end
    end

    // output only moves after the synchronised input has held still
    AST_FILTER_PERSIST: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(clean) |-> ($past(s2) == $past(s2, 2))); // R9
endmodule

// File: rtl/i2cfe_bus_cond.sv
module i2cfe_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic start,
    output logic stop,
    output logic scl_rise,
    output logic scl_fall
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    always_comb begin
        start    = scl & scl_q & sda_q & ~sda;
        stop     = scl & scl_q & ~sda_q & sda;
        scl_rise = scl & ~scl_q;
        scl_fall = ~scl & scl_q;
    end

    AST_COND_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start, stop, scl_rise, scl_fall})); // R1
endmodule

// File: rtl/i2cfe_slave.sv
module i2cfe_slave
    import i2cfe_pkg::*;
#(
    parameter int FILT_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [CE_W-1:0]   chip_en,
    input  logic              prot_locked,
    input  logic              wr_busy,
    output logic              ev_start,
    output logic              ev_stop,
    output logic              ev_sel,
    output logic              sel_target,
    output logic              sel_rw,
    output logic              ev_byte,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              ev_mack,
    output logic              ev_mnack,
    output logic              rd_req,
    input  logic [BYTE_W-1:0] rd_data
);
    localparam int BCW = $clog2(BYTE_W + 1);
    localparam logic [BCW-1:0] LAST_BIT = BCW'(BYTE_W - 1);
    localparam logic [BCW-1:0] FULL     = BCW'(BYTE_W);

    logic [1:0] raw_lines, clean_lines;
    logic       scl_f, sda_f;
    logic       cond_start, cond_stop, scl_rise, scl_fall;

    assign raw_lines = {scl_i, sda_i};

    for (genvar g = 0; g < 2; g++) begin : g_filt
        i2cfe_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (raw_lines[g]),
            .clean (clean_lines[g])
        );
    end

    assign scl_f = clean_lines[1];
    assign sda_f = clean_lines[0];

    i2cfe_bus_cond u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl      (scl_f),
        .sda      (sda_f),
        .start    (cond_start),
        .stop     (cond_stop),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall)
    );

    fe_state_t           state, nxt;
    logic [BCW-1:0]      bit_cnt;
    logic [BYTE_W-2:0]   shreg;
    logic [BYTE_W-2:0]   txreg;
    logic [BYTE_W-1:0]   sel_byte;
    logic                sel_hit, sel_is_prot;

    assign sel_byte    = {shreg, sda_f};
    assign sel_is_prot = (sel_byte[BYTE_W-1 -: TYPE_W] == ID_PROT);
    assign sel_hit     = (sel_byte[CE_W:1] == chip_en) &&
                         ((sel_byte[BYTE_W-1 -: TYPE_W] == ID_ARRAY) ||
                          (sel_is_prot && !prot_locked));

    // next-state logic
    always_comb begin
        nxt = state;
        if (wr_busy) begin
            nxt = ST_IDLE;
        end else if (cond_start) begin
            nxt = ST_SEL;
        end else if (cond_stop) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:    nxt = ST_IDLE;
                ST_SEL: begin
                    if (scl_rise && bit_cnt == LAST_BIT && !sel_hit) nxt = ST_IDLE;
                    else if (scl_fall && bit_cnt == FULL)            nxt = ST_SEL_ACK;
                end
                ST_SEL_ACK: if (scl_fall) nxt = sel_rw ? ST_TX : ST_RX;
                ST_RX:      if (scl_fall && bit_cnt == FULL) nxt = ST_RX_ACK;
                ST_RX_ACK:  if (scl_fall) nxt = ST_RX;
                ST_TX:      if (scl_fall && bit_cnt == LAST_BIT) nxt = ST_TX_ACK;
                ST_TX_ACK: begin
                    if (scl_rise && sda_f) nxt = ST_IDLE;
                    else if (scl_fall)     nxt = ST_TX;
                end
                default:    nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe     <= 1'b0;
            ev_start   <= 1'b0;
            ev_stop    <= 1'b0;
            ev_sel     <= 1'b0;
            sel_target <= 1'b0;
            sel_rw     <= 1'b0;
            ev_byte    <= 1'b0;
            rx_byte    <= '0;
            ev_mack    <= 1'b0;
            ev_mnack   <= 1'b0;
            rd_req     <= 1'b0;
            bit_cnt    <= '0;
            shreg      <= '0;
            txreg      <= '0;
        end else begin
            ev_start <= 1'b0;
            ev_stop  <= 1'b0;
            ev_sel   <= 1'b0;
            ev_byte  <= 1'b0;
            ev_mack  <= 1'b0;
            ev_mnack <= 1'b0;
            rd_req   <= 1'b0;
            if (wr_busy) begin
                sda_oe  <= 1'b0;
                bit_cnt <= '0;
            end else if (cond_start) begin
                ev_start <= 1'b1;
                sda_oe   <= 1'b0;
                bit_cnt  <= '0;
            end else if (cond_stop) begin
                ev_stop <= 1'b1;
                sda_oe  <= 1'b0;
            end else begin
                unique case (state)
                    ST_SEL: begin
                        if (scl_rise) begin
                            shreg   <= sel_byte[BYTE_W-2:0];
                            bit_cnt <= bit_cnt + 1'b1;
                            if (bit_cnt == LAST_BIT && sel_hit) begin
                                ev_sel     <= 1'b1;
                                sel_target <= sel_is_prot;
                                sel_rw     <= sel_byte[0];
                                rd_req     <= sel_byte[0];
                            end
                        end else if (scl_fall && bit_cnt == FULL) begin
                            sda_oe <= 1'b1;
                        end
                    end
                    ST_SEL_ACK: begin
                        if (scl_fall) begin
                            sda_oe  <= sel_rw ? ~rd_data[BYTE_W-1] : 1'b0;
                            txreg   <= rd_data[BYTE_W-2:0];
                            bit_cnt <= '0;
                        end
                    end
                    ST_RX: begin
                        if (scl_rise) begin
                            shreg   <= sel_byte[BYTE_W-2:0];
                            bit_cnt <= bit_cnt + 1'b1;
                            if (bit_cnt == LAST_BIT) begin
                                ev_byte <= 1'b1;
                                rx_byte <= sel_byte;
                            end
                        end else if (scl_fall && bit_cnt == FULL) begin
                            sda_oe <= 1'b1;
                        end
                    end
                    ST_RX_ACK: begin
                        if (scl_fall) begin
                            sda_oe  <= 1'b0;
                            bit_cnt <= '0;
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            sda_oe  <= (bit_cnt == LAST_BIT) ? 1'b0 : ~txreg[BYTE_W-2];
                            txreg   <= {txreg[BYTE_W-3:0], 1'b0};
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    ST_TX_ACK: begin
                        if (scl_rise) begin
                            ev_mnack <= sda_f;
                            ev_mack  <= ~sda_f;
                            rd_req   <= ~sda_f;
                        end else if (scl_fall) begin
                            sda_oe  <= ~rd_data[BYTE_W-1];
                            txreg   <= rd_data[BYTE_W-2:0];
                            bit_cnt <= '0;
                        end
                    end
                    default: sda_oe <= 1'b0;
                endcase
            end
        end
    end

    AST_OE_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_f); // R10
    AST_SEL_ACK_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEL_ACK) |-> sda_oe); // R2
    AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        wr_busy |=> (!sda_oe && !ev_start && !ev_sel && !ev_byte && !rd_req)); // R7
    AST_NACK_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
        ev_mnack |-> (state == ST_IDLE)); // R6
    AST_RESTART_FRAMES: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_start && !wr_busy) |=> (state == ST_SEL && bit_cnt == '0)); // R8
endmodule

// File: tb/i2cfe_slave_tb_top.sv
module i2cfe_slave_tb_top;
    localparam int Q = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sda_oe;
    logic [2:0] chip_en = 3'b101;
    logic       prot_locked = 1'b0;
    logic       wr_busy = 1'b0;
    logic       ev_start, ev_stop, ev_sel, sel_target, sel_rw, ev_byte;
    logic [7:0] rx_byte;
    logic       ev_mack, ev_mnack, rd_req;
    logic [7:0] rd_data = 8'h00;
    logic       sda_line;

    assign sda_line = m_sda & ~sda_oe;

    i2cfe_slave #(.FILT_LEN(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
        .chip_en(chip_en), .prot_locked(prot_locked), .wr_busy(wr_busy),
        .ev_start(ev_start), .ev_stop(ev_stop), .ev_sel(ev_sel), .sel_target(sel_target),
        .sel_rw(sel_rw), .ev_byte(ev_byte), .rx_byte(rx_byte), .ev_mack(ev_mack),
        .ev_mnack(ev_mnack), .rd_req(rd_req), .rd_data(rd_data)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int c_start = 0, c_stop = 0, c_sel = 0, c_byte = 0, c_mack = 0, c_mnack = 0;
    int rd_idx = 0;
    int oe_bad = 0;
    logic oe_prev = 1'b0;
    bit done = 1'b0;

    function automatic logic [7:0] pat(int i);
        return 8'hA5 ^ 8'(i * 59);
    endfunction

    always @(negedge clk) begin
        if (ev_start) c_start++;
        if (ev_stop)  c_stop++;
        if (ev_sel)   c_sel++;
        if (ev_byte)  c_byte++;
        if (ev_mack)  c_mack++;
        if (ev_mnack) c_mnack++;
        if (rd_req) begin
            rd_data <= pat(rd_idx);
            rd_idx++;
        end
        if (sda_oe && !oe_prev && m_scl) oe_bad++;
        oe_prev = sda_oe;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wclk(Q);
        m_scl = 1'b1; wclk(Q);
        m_sda = 1'b0; wclk(Q);
        m_scl = 1'b0; wclk(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wclk(Q);
        m_scl = 1'b1; wclk(Q);
        m_sda = 1'b1; wclk(Q);
    endtask

    task automatic xfer_bit(input logic b, output logic seen);
        m_sda = b;    wclk(Q);
        m_scl = 1'b1; wclk(Q);
        seen = sda_line; wclk(Q);
        m_scl = 1'b0; wclk(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) xfer_bit(v[i], s);
        xfer_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] v);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            xfer_bit(1'b1, s);
            v[i] = s;
        end
        xfer_bit(~give_ack, s);
    endtask

    task automatic t_reset();
        check(sda_oe == 1'b0, "R1", "sda_oe after reset", sda_oe, 0);
        check(c_start + c_stop + c_sel + c_byte == 0, "R1", "events after reset",
              c_start + c_stop + c_sel + c_byte, 0);
    endtask

    task automatic t_write_array();
        logic ack; int s0, b0, p0;
        s0 = c_sel; b0 = c_byte; p0 = c_stop;
        bus_start();
        check(c_start == 1, "R1", "start count", c_start, 1);
        send_byte(8'b1010_101_0, ack);
        check(ack, "R2", "array select ack", ack, 1);
        check(c_sel == s0 + 1 && sel_target == 1'b0 && sel_rw == 1'b0, "R2",
              "sel event/target/rw", {c_sel - s0, 3'b0, sel_target, 3'b0, sel_rw}, 'h100);
        send_byte(8'h3C, ack);
        check(ack && c_byte == b0 + 1 && rx_byte == 8'h3C, "R5", "first data byte", rx_byte, 'h3C);
        send_byte(8'hC3, ack);
        check(ack && c_byte == b0 + 2 && rx_byte == 8'hC3, "R5", "second data byte", rx_byte, 'hC3);
        bus_stop();
        check(c_stop == p0 + 1, "R1", "stop count", c_stop - p0, 1);
    endtask

    task automatic t_mismatch();
        logic ack; int s0, b0;
        s0 = c_sel; b0 = c_byte;
        bus_start();
        send_byte(8'b1010_011_0, ack);
        check(!ack && c_sel == s0, "R4", "wrong chip enable nack", ack, 0);
        send_byte(8'h55, ack);
        check(!ack && c_byte == b0, "R4", "standby after mismatch", c_byte - b0, 0);
        bus_stop();
        bus_start();
        send_byte(8'b1100_101_0, ack);
        check(!ack && c_sel == s0, "R4", "unknown type nack", ack, 0);
        bus_stop();
    endtask

    task automatic t_prot();
        logic ack; int s0;
        prot_locked = 1'b0;
        bus_start();
        send_byte(8'b0110_101_0, ack);
        check(ack && sel_target == 1'b1, "R3", "protection select unlocked", sel_target, 1);
        bus_stop();
        prot_locked = 1'b1;
        s0 = c_sel;
        bus_start();
        send_byte(8'b0110_101_0, ack);
        check(!ack, "R3", "locked protection write nack", ack, 0);
        bus_stop();
        bus_start();
        send_byte(8'b0110_101_1, ack);
        check(!ack && c_sel == s0, "R3", "locked protection read nack", c_sel - s0, 0);
        bus_stop();
        bus_start();
        send_byte(8'b1010_101_0, ack);
        check(ack && sel_target == 1'b0, "R3", "array still selectable when locked", ack, 1);
        bus_stop();
        prot_locked = 1'b0;
    endtask

    task automatic t_read();
        logic ack; logic [7:0] v; int i0, ma0, mn0;
        i0 = rd_idx; ma0 = c_mack; mn0 = c_mnack;
        bus_start();
        send_byte(8'b1010_101_1, ack);
        check(ack && sel_rw == 1'b1, "R6", "read select ack", sel_rw, 1);
        recv_byte(1'b1, v);
        check(v == pat(i0), "R6", "first read byte", v, pat(i0));
        check(c_mack == ma0 + 1, "R6", "master ack event", c_mack - ma0, 1);
        recv_byte(1'b0, v);
        check(v == pat(i0 + 1), "R6", "second read byte", v, pat(i0 + 1));
        check(c_mnack == mn0 + 1, "R6", "master noack event", c_mnack - mn0, 1);
        recv_byte(1'b0, v);
        check(v == 8'hFF && rd_idx == i0 + 2, "R6", "released after noack", v, 'hFF);
        bus_stop();
    endtask

    task automatic t_restart();
        logic ack; logic [7:0] v; int s0, i0;
        s0 = c_sel;
        bus_start();
        send_byte(8'b1010_101_0, ack);
        send_byte(8'h10, ack);
        bus_start();
        i0 = rd_idx;
        send_byte(8'b1010_101_1, ack);
        check(ack && c_sel == s0 + 2 && sel_rw == 1'b1, "R8", "select after repeated start",
              c_sel - s0, 2);
        recv_byte(1'b0, v);
        check(v == pat(i0), "R8", "read after repeated start", v, pat(i0));
        bus_stop();
    endtask

    task automatic t_busy();
        logic ack; int s0, p0, e0;
        s0 = c_start; p0 = c_stop; e0 = c_sel;
        wr_busy = 1'b1;
        bus_start();
        send_byte(8'b1010_101_0, ack);
        check(!ack, "R7", "no ack while busy", ack, 0);
        check(c_start == s0 && c_sel == e0, "R7", "no events while busy", c_start - s0, 0);
        bus_stop();
        check(c_stop == p0, "R7", "stop ignored while busy", c_stop - p0, 0);
        wr_busy = 1'b0;
        wclk(Q);
    endtask

    task automatic t_glitch();
        int s0, p0;
        s0 = c_start; p0 = c_stop;
        m_sda = 1'b0; wclk(2);
        m_sda = 1'b1; wclk(Q);
        check(c_start == s0 && c_stop == p0, "R9", "short SDA pulse ignored", c_start - s0, 0);
        m_sda = 1'b0; wclk(12);
        m_sda = 1'b1; wclk(Q);
        check(c_start == s0 + 1 && c_stop == p0 + 1, "R9", "long SDA pulse accepted",
              c_start - s0, 1);
    endtask

    initial begin
        wclk(5);
        rst_n = 1'b1;
        wclk(10);
        t_reset();
        t_write_array();
        t_mismatch();
        t_prot();
        t_read();
        t_restart();
        t_busy();
        t_glitch();
        check(oe_bad == 0, "R10", "ack enable rose with SCL high", oe_bad, 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule